// File: doc/BRIEF.md
# Programmable Signed-Digit FIR Filter

This block is a linear-phase FIR filter whose coefficients are assembled from a shared pool of signed power-of-two digit slices. It has no multipliers. Each slice adds a mirrored sample pair, shifts the sum left by a programmed amount, and adds or subtracts it in the output sum. Each slice has a split bit, which switches a unit delay into or out of the slice's forward and backward sample paths. An inserted delay opens a new tap. A bypassed delay adds the slice's digit to the current tap. The same pool can therefore form many short-precision taps or a few high-precision taps.

The filter takes one 16-bit sample on every clock edge and returns one rounded, saturated 16-bit result per edge through a single output register. Slice settings are written through an addressed configuration port. The intended time to write them is while the filter is held in reset, because a synchronous reset clears only the sample history and the output.

Top module: `csd_fir`

## Requirements
- R1: While `rst` is high at a clock edge, every delay register and the output register are cleared, so `resultOut` reads 0. Slice settings are not affected by reset.
- R2: An edge with `cfgWrite` high stores `cfgShift` (0 to 15), `cfgNeg` and `cfgSplit` into the slice numbered `cfgAddr`. No other slice changes. Writes are accepted whether or not `rst` is high.
- R3: A slice contributes the digit value +2^shift, or -2^shift when its negate bit is 1. A tap coefficient is the sum of the digits of the slices assigned to it, in units of 2^-15.
- R4: Slices are assigned to taps in address order. Slice 0 begins tap 0. Each slice i >= 1 with its split bit set begins the next tap, so the number of distinct taps T is one plus the number of split bits set in slices 1 and above.
- R5: The filter is symmetric with length 2T: coefficient k multiplies the sum x[n-k] + x[n-(2T-1-k)].
- R6: One sample is taken at every edge. After the edge that takes x[n], `resultOut` shows y[n] = sum over k < T of h[k]*(x[n-k] + x[n-(2T-1-k)]), scaled as in R7.
- R7: The full-precision sum is rounded by adding 2^14 and shifting right arithmetically by 15 bits. Exact halves therefore round toward positive infinity.
- R8: A rounded value above 32767 gives 32767 and one below -32768 gives -32768.
- R9: The split bit of slice 0 does not open a tap. When it is set, the whole response is delayed by one extra sample.
- R10: Samples presented while `rst` is high have no effect on any later output.
- R11: After 33 consecutive zero samples, the output is 0, whatever the settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous reset of the sample history and the output |
| sampleIn | input | 16 | Signed input sample, taken at every edge |
| cfgWrite | input | 1 | Store the slice fields at this edge |
| cfgAddr | input | 4 | Number of the slice to be written |
| cfgShift | input | 4 | Power-of-two exponent of the digit |
| cfgNeg | input | 1 | 1 makes the digit negative |
| cfgSplit | input | 1 | 1 inserts the unit delay before the slice |
| resultOut | output | 16 | Signed rounded and saturated filter output |

## Verification
A wrong split bit or a missed delay register moves the mirrored partner of some taps. The error shows on the first output after a nonzero sample reaches the misplaced tap, which is at most 2T samples after an impulse. A wrong shift or sign in one slice changes the response immediately, by a power of two times the mirrored-pair sum. A rounding or clamping fault appears only on halfway values or large sums. The bench therefore sweeps several pool partitions with deterministic pseudo-random streams, directed halfway inputs, and inputs large enough to clamp. It also sends runs of zeros, and applies noise during reset that must leave no trace.

// File: rtl/csd_fir_pkg.sv
package csd_fir_pkg;
  localparam int SHIFT_W = 4;

  typedef struct packed {
    logic              split;
    logic              neg;
    logic [SHIFT_W-1:0] shift;
  } sliceCfg_t;

  typedef struct packed {
    logic clearLine;
    logic cfgLoad;
  } firStrobes_t;
endpackage

// File: rtl/csd_fir_ctrl.sv
module csd_fir_ctrl
  import csd_fir_pkg::*;
(
  input  logic        rst,
  input  logic        cfgWrite,
  output firStrobes_t strobes
);
  // Reset clears only sample history; configuration writes pass at any time.
  always_comb begin
    strobes.clearLine = rst;
    strobes.cfgLoad   = cfgWrite;
  end
endmodule

// File: rtl/csd_fir_datapath.sv
module csd_fir_datapath
  import csd_fir_pkg::*;
#(
  parameter int NUM_SLICES = 16,
  parameter int DATA_W     = 16,
  parameter int FRAC_W     = 15,
  localparam int ADDR_W    = $clog2(NUM_SLICES),
  localparam int CNT_W     = $clog2(NUM_SLICES) + 1
) (
  input  logic                  clk,
  input  firStrobes_t           strobes,
  input  logic [ADDR_W-1:0]     cfgAddr,
  input  sliceCfg_t             cfgField,
  input  logic [DATA_W-1:0]     sampleIn,
  output logic [DATA_W-1:0]     resultOut,
  output logic [NUM_SLICES-1:0] wrSel,
  output logic [CNT_W-1:0]      tapCount
);
  localparam int PRE_W = DATA_W + 1;
  localparam int MAX_SH = (1 << SHIFT_W) - 1;
  localparam int ACC_W = PRE_W + MAX_SH + $clog2(NUM_SLICES) + 1;
  localparam logic signed [ACC_W-1:0] HALF   = ACC_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - ACC_W'(1);

  logic [SHIFT_W-1:0]       shiftArr [NUM_SLICES];
  logic [NUM_SLICES-1:0]    negVec;
  logic [NUM_SLICES-1:0]    splitVec;
  logic signed [DATA_W-1:0] fwd [NUM_SLICES];
  logic signed [DATA_W-1:0] bwd [NUM_SLICES];
  logic signed [DATA_W-1:0] turnReg;
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  rounded;
  logic signed [ACC_W-1:0]  clamped;
  logic [DATA_W-1:0]        resultReg;

  // Configuration store, one entry per digit slice.
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_SLICES; i++) begin
      if (wrSel[i]) begin
        shiftArr[i] <= cfgField.shift;
        negVec[i]   <= cfgField.neg;
        splitVec[i] <= cfgField.split;
      end
    end
  end

  // Forward and backward sample paths with a switchable unit delay per slice.
  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
    assign wrSel[i] = strobes.cfgLoad && (cfgAddr == ADDR_W'(i));
    logic signed [DATA_W-1:0] fReg;
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (strobes.clearLine) fReg <= '0;
        else                   fReg <= $signed(sampleIn);
      end
      assign fwd[0] = splitVec[0] ? fReg : $signed(sampleIn);
    end else begin : g_body
      logic signed [DATA_W-1:0] bReg;
      always_ff @(posedge clk) begin
        if (strobes.clearLine) begin
          fReg <= '0;
          bReg <= '0;
        end else begin
          fReg <= fwd[i-1];
          bReg <= bwd[i];
        end
      end
      assign fwd[i]   = splitVec[i] ? fReg : fwd[i-1];
      assign bwd[i-1] = splitVec[i] ? bReg : bwd[i];
    end
  end

  // Turn-around delay joining the two paths at the far end.
  always_ff @(posedge clk) begin
    if (strobes.clearLine) turnReg <= '0;
    else                   turnReg <= fwd[NUM_SLICES-1];
  end
  assign bwd[NUM_SLICES-1] = turnReg;

  // Pre-add, shift and signed accumulation over the whole pool.
  always_comb begin
    acc = '0;
    for (int i = 0; i < NUM_SLICES; i++) begin : sum_loop
      logic signed [PRE_W-1:0] pre;
      logic signed [ACC_W-1:0] term;
      pre  = {fwd[i][DATA_W-1], fwd[i]} + {bwd[i][DATA_W-1], bwd[i]};
      term = {{(ACC_W-PRE_W){pre[PRE_W-1]}}, pre} <<< shiftArr[i];
      acc  = negVec[i] ? (acc - term) : (acc + term);
    end
    rounded = (acc + HALF) >>> FRAC_W;
    if (rounded > SAT_HI)      clamped = SAT_HI;
    else if (rounded < SAT_LO) clamped = SAT_LO;
    else                       clamped = rounded;
  end

  always_ff @(posedge clk) begin
    if (strobes.clearLine) resultReg <= '0;
    else                   resultReg <= clamped[DATA_W-1:0];
  end
  assign resultOut = resultReg;

  always_comb begin
    tapCount = CNT_W'(1);
    for (int i = 1; i < NUM_SLICES; i++) tapCount = tapCount + CNT_W'(splitVec[i]);
  end
endmodule

// File: rtl/csd_fir.sv
module csd_fir
  import csd_fir_pkg::*;
#(
  parameter int NUM_SLICES = 16,
  parameter int DATA_W     = 16,
  parameter int FRAC_W     = 15,
  localparam int ADDR_W    = $clog2(NUM_SLICES),
  localparam int CNT_W     = $clog2(NUM_SLICES) + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DATA_W-1:0]  sampleIn,
  input  logic               cfgWrite,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [SHIFT_W-1:0] cfgShift,
  input  logic               cfgNeg,
  input  logic               cfgSplit,
  output logic [DATA_W-1:0]  resultOut
);
  firStrobes_t           strobes;
  sliceCfg_t             cfgField;
  logic [NUM_SLICES-1:0] wrSel;
  logic [CNT_W-1:0]      tapCount;

  assign cfgField = '{split: cfgSplit, neg: cfgNeg, shift: cfgShift};

  csd_fir_ctrl u_ctrl (
    .rst      (rst),
    .cfgWrite (cfgWrite),
    .strobes  (strobes)
  );

  csd_fir_datapath #(
    .NUM_SLICES (NUM_SLICES),
    .DATA_W     (DATA_W),
    .FRAC_W     (FRAC_W)
  ) u_dp (
    .clk       (clk),
    .strobes   (strobes),
    .cfgAddr   (cfgAddr),
    .cfgField  (cfgField),
    .sampleIn  (sampleIn),
    .resultOut (resultOut),
    .wrSel     (wrSel),
    .tapCount  (tapCount)
  );
endmodule

// File: rtl/csd_fir_checker.sv
module csd_fir_checker #(
  parameter int NUM_SLICES = 16,
  parameter int DATA_W     = 16,
  localparam int ADDR_W    = $clog2(NUM_SLICES),
  localparam int CNT_W     = $clog2(NUM_SLICES) + 1,
  localparam int LIMIT     = 2 * NUM_SLICES + 1,
  localparam int RUN_W     = $clog2(LIMIT + 1)
) (
  input logic                  clk,
  input logic                  rst,
  input logic [DATA_W-1:0]     sampleIn,
  input logic [DATA_W-1:0]     resultOut,
  input logic                  cfgWrite,
  input logic [ADDR_W-1:0]     cfgAddr,
  input logic [NUM_SLICES-1:0] wrSel,
  input logic [CNT_W-1:0]      tapCount
);
  logic             pastRst = 1'b0;
  logic [RUN_W-1:0] zeroRun = '0;

  always_ff @(posedge clk) begin
    pastRst <= rst;
    if (rst)                                zeroRun <= RUN_W'(LIMIT);
    else if (sampleIn != '0)                zeroRun <= '0;
    else if (zeroRun < RUN_W'(LIMIT))       zeroRun <= zeroRun + RUN_W'(1);
  end

  // R1: an edge taken in reset leaves a zero output.
  always_ff @(posedge clk) begin
    if (pastRst) p_reset_zero_r1: assert (resultOut == '0);
  end

  // R2: a write targets exactly one slice.
  p_single_slice_r2: assert property (@(posedge clk) disable iff (rst)
    (cfgWrite && (32'(cfgAddr) < NUM_SLICES)) |-> $onehot(wrSel));

  // R4: tap partition changes only through a configuration write.
  p_taps_stable_r4: assert property (@(posedge clk) disable iff (rst)
    !cfgWrite |=> $stable(tapCount));

  // R11: a full window of zero samples flushes the output.
  p_zero_flush_r11: assert property (@(posedge clk) disable iff (rst)
    ((zeroRun >= RUN_W'(LIMIT - 1)) && (sampleIn == '0)) |=> (resultOut == '0));
endmodule

bind csd_fir csd_fir_checker #(
  .NUM_SLICES (NUM_SLICES),
  .DATA_W     (DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sampleIn  (sampleIn),
  .resultOut (resultOut),
  .cfgWrite  (cfgWrite),
  .cfgAddr   (cfgAddr),
  .wrSel     (wrSel),
  .tapCount  (tapCount)
);

// File: tb/csd_fir_test.sv
module csd_fir_test;
  localparam int S = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [15:0]       sampleIn = '0;
  logic              cfgWrite = 1'b0;
  logic [3:0]        cfgAddr = '0;
  logic [3:0]        cfgShift = '0;
  logic              cfgNeg = 1'b0;
  logic              cfgSplit = 1'b0;
  logic signed [15:0] resultOut;

  always #4 clk = ~clk;

  csd_fir uut (
    .clk(clk), .rst(rst), .sampleIn(sampleIn), .cfgWrite(cfgWrite),
    .cfgAddr(cfgAddr), .cfgShift(cfgShift), .cfgNeg(cfgNeg),
    .cfgSplit(cfgSplit), .resultOut(resultOut)
  );

  int vectors = 0;
  int misses = 0;
  bit finished = 1'b0;
  int hist [64];
  int bShift [S];
  bit bNeg [S];
  bit bSplit [S];
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Behavioural model built from the programmed fields (R3 R4 R5 R7 R8 R9).
  function automatic int modelY();
    longint h [S];
    longint acc = 0;
    longint y;
    int t = 0;
    int taps;
    int d = bSplit[0] ? 1 : 0;
    for (int i = 0; i < S; i++) h[i] = 0;
    for (int i = 0; i < S; i++) begin
      if (i > 0 && bSplit[i]) t++;
      h[t] += bNeg[i] ? -(longint'(1) << bShift[i]) : (longint'(1) << bShift[i]);
    end
    taps = t + 1;
    for (int k = 0; k < taps; k++)
      acc += h[k] * longint'(hist[d + k] + hist[d + 2 * taps - 1 - k]);
    y = (acc + 16384) >>> 15;
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    return int'(y);
  endfunction

  function automatic int nextRand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return int'($signed(lfsr));
  endfunction

  task automatic applySample(int x, string tag);
    int exp;
    sampleIn = 16'(x);
    for (int j = 63; j > 0; j--) hist[j] = hist[j-1];
    hist[0] = x;
    exp = modelY();
    @(posedge clk);
    @(negedge clk);
    check(tag, int'(resultOut), exp);
  endtask

  // Program every slice under reset with noise on the input (R1 R2 R10).
  task automatic loadConfig();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < S; i++) begin
      cfgWrite = 1'b1;
      cfgAddr  = 4'(i);
      cfgShift = 4'(bShift[i]);
      cfgNeg   = bNeg[i];
      cfgSplit = bSplit[i];
      sampleIn = 16'(nextRand());
      @(negedge clk);
    end
    cfgWrite = 1'b0;
    sampleIn = 16'h7ABC;
    @(negedge clk);
    check("R1 reset output", int'(resultOut), 0);
    for (int j = 0; j < 64; j++) hist[j] = 0;
    rst = 1'b0;
  endtask

  task automatic runRandom(int n, string tag);
    for (int i = 0; i < n; i++)
      applySample(nextRand(), (i < 2 * S + 1) ? "R10 history after reset" : tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL R6 watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < 64; j++) hist[j] = 0;

    // Config A: one digit per tap, distinct shifts per address (R2 R3 R5).
    for (int i = 0; i < S; i++) begin
      bShift[i] = i; bNeg[i] = i[0]; bSplit[i] = (i > 0);
    end
    loadConfig();
    applySample(1, "R5 impulse");
    for (int i = 0; i < 2 * S + 1; i++) applySample(0, "R5 impulse tail");
    runRandom(60, "R2 R3 addressed digits");

    // Config B: two digits per tap, then a zero run (R4 R11).
    for (int i = 0; i < S; i++) begin
      bShift[i] = 14 - (i % 7); bNeg[i] = (i % 3 == 0); bSplit[i] = (i > 0) && !i[0];
    end
    loadConfig();
    runRandom(60, "R4 two digits per tap");
    for (int i = 0; i < 2 * S + 1; i++) applySample(0, "R11 zero flush");
    applySample(0, "R11 zero flush settled");

    // Config C: whole pool in one tap with net coefficient one (R7).
    for (int i = 0; i < S; i++) begin
      bShift[i] = 2 + (i >> 1); bNeg[i] = i[0]; bSplit[i] = 1'b0;
    end
    bShift[0] = 1; bNeg[0] = 1'b0; bShift[1] = 0; bNeg[1] = 1'b1;
    loadConfig();
    begin
      int rv [12] = '{16384, 0, 16383, 0, -16384, 0, -16385, 0, 8192, 8192, -8192, -8193};
      foreach (rv[k]) applySample(rv[k], "R7 rounding halves");
    end
    runRandom(40, "R6 single tap pair");

    // Config D: as C with the head delay switched in (R9).
    bSplit[0] = 1'b1;
    loadConfig();
    applySample(1 << 14, "R9 head delay");
    applySample(0, "R9 head delay");
    applySample(0, "R9 head delay");
    runRandom(40, "R9 head delay");

    // Config E: large coefficient for clamping (R8).
    for (int i = 0; i < S; i++) begin
      bShift[i] = 15; bNeg[i] = 1'b0; bSplit[i] = 1'b0;
    end
    loadConfig();
    begin
      int sv [8] = '{1000, 1000, 1100, -1000, -1100, -1100, 32767, -32768};
      foreach (sv[k]) applySample(sv[k], "R8 saturation");
    end
    runRandom(40, "R8 saturation");

    // Config F: mixed partition, several digits in one tap (R3 R4 R6).
    for (int i = 0; i < S; i++) begin
      bShift[i] = (i * 5) % 16; bNeg[i] = (i % 4 == 1); bSplit[i] = (i == 3) || (i == 4) || (i == 9) || (i == 15);
    end
    loadConfig();
    runRandom(80, "R6 mixed partition");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule